// File: doc/BRIEF.md
# One-Hot Select Integer ALU

This block is the arithmetic and logic unit of a scalar integer execute stage. It is purely combinational. It takes two 32-bit operands and returns one 32-bit result. Before the operands arrive, the execute stage has already chosen each of them from a register value, the program counter or a decoded immediate. A 12-bit select vector, with exactly one bit set, chooses the operation. The block covers addition, subtraction, signed and unsigned comparison, four bitwise functions, three shifts and an upper-immediate pass-through.

The addition path has several users besides plain add instructions. It forms load and store addresses, and it forms link addresses when the stage feeds in the program counter and the constant 4. Subtraction and both comparisons share that one adder. They feed it the inverted second operand and a carry-in of 1. All three shifts share a single barrel shifter. The shift amount comes from the five least significant bits of the second operand.

Top module: `oh_alu`

## Requirements
- R1: Select bit 0 (add) gives the sum of both operands modulo 2^32. For example, operand A = 0x1C000000 and operand B = 4 gives 0x1C000004, and 0xFFFFFFFF + 1 gives 0.
- R2: Select bit 1 (subtract) gives A minus B modulo 2^32. When A equals B, the result is 0.
- R3: Select bit 2 (signed less-than) treats both operands as two's complement. It returns 1 in bit 0 when A < B and 0 otherwise, and result bits 31:1 are always 0.
- R4: Select bit 3 (unsigned less-than) returns 1 in bit 0 when A < B as unsigned numbers and 0 otherwise, and result bits 31:1 are always 0.
- R5: Select bit 4 gives A AND B, bit 5 gives NOT (A OR B), bit 6 gives A OR B, and bit 7 gives A XOR B.
- R6: Select bit 8 shifts A left by B[4:0] and fills with zeros. Bits 31:5 of B have no effect, and a shift amount of 0 returns A unchanged.
- R7: Select bit 9 shifts A right by B[4:0] and fills with zeros. Bits 31:5 of B have no effect.
- R8: Select bit 10 shifts A right by B[4:0] and fills with copies of A[31]. Bits 31:5 of B have no effect.
- R9: Select bit 11 (upper immediate) returns B unchanged, whatever the value of A. B already carries the 20-bit immediate in bits 31:12, with zeros in bits 11:0.
- R10: An all-zero select vector gives a result of 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 12 | One-hot operation select, with bit positions as listed in the requirements |
| src_a | input | 32 | First operand: a register value or the program counter |
| src_b | input | 32 | Second operand: a register value or an immediate; bits 4:0 give the shift amount |
| result | output | 32 | Result of the selected operation |

## Verification
The block holds no state, so any internal fault appears on `result` in the same cycle that the faulty operation is selected. Each fault shows up only under particular operations:
- If the adder's invert or carry-in control is wrong, subtract gives the sum instead of the difference, and the comparisons flip near zero and at the sign boundary.
- If the shifter's bit reversal is wrong, only left shifts are affected.
- If the fill bit is wrong, only arithmetic right shifts of negative values are affected.

For these reasons the directed cases cover shift amounts 0 and 31, the extreme signed and unsigned values, and values that carry across the full width.

// File: rtl/oh_alu_pkg.sv
package oh_alu_pkg;

  localparam int OP_ADD  = 0;
  localparam int OP_SUB  = 1;
  localparam int OP_SLT  = 2;
  localparam int OP_SLTU = 3;
  localparam int OP_AND  = 4;
  localparam int OP_NOR  = 5;
  localparam int OP_OR   = 6;
  localparam int OP_XOR  = 7;
  localparam int OP_SLL  = 8;
  localparam int OP_SRL  = 9;
  localparam int OP_SRA  = 10;
  localparam int OP_LUI  = 11;
  localparam int NUM_OPS = 12;

  // Signed A < B, taken from the difference A - B. The difference bit alone
  // is wrong on overflow, which occurs only when the operand signs differ.
  function automatic logic signed_less(input logic a_msb, input logic b_msb,
                                       input logic diff_msb);
    return (a_msb != b_msb) ? a_msb : diff_msb;
  endfunction

  // Unsigned A < B: computing A + ~B + 1 leaves no carry out exactly when A < B.
  function automatic logic unsigned_less(input logic carry_out);
    return ~carry_out;
  endfunction

endpackage

// File: rtl/oh_alu_addsub.sv
module oh_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         negate_b,
  output logic [W-1:0] sum,
  output logic         carry_out
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide_sum;

  assign b_eff     = opb ^ {W{negate_b}};
  assign wide_sum  = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, negate_b};
  assign sum       = wide_sum[W-1:0];
  assign carry_out = wide_sum[W];

endmodule

// File: rtl/oh_alu_bitwise.sv
module oh_alu_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] and_out,
  output logic [W-1:0] nor_out,
  output logic [W-1:0] or_out,
  output logic [W-1:0] xor_out
);

  assign and_out = opa & opb;
  assign or_out  = opa | opb;
  assign nor_out = ~or_out;
  assign xor_out = opa ^ opb;

endmodule

// File: rtl/oh_alu_shift.sv
module oh_alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   dout
);

  // A left shift is done as a right shift of the bit-reversed input,
  // followed by reversing the output back.
  logic [W-1:0]        oriented;
  logic [SHW:0][W-1:0] stage;
  logic                shift_fill;

  assign shift_fill = arith & ~left & din[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign oriented[i] = left ? din[W-1-i] : din[i];
  end

  assign stage[0] = oriented;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{shift_fill}}, stage[s][W-1:STEP]}
                               : stage[s];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign dout[i] = left ? stage[SHW][W-1-i] : stage[SHW][i];
  end

endmodule

// File: rtl/oh_alu.sv
module oh_alu
  import oh_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [11:0]       op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result
);

  localparam int SHW = $clog2(DATA_W);

  logic                            use_negate;
  logic [DATA_W-1:0]               adder_sum;
  logic                            adder_carry;
  logic                            lt_signed;
  logic                            lt_unsigned;
  logic [DATA_W-1:0]               and_v, nor_v, or_v, xor_v;
  logic [DATA_W-1:0]               shift_v;
  logic [NUM_OPS-1:0][DATA_W-1:0]  lane;
  logic                            sel_valid;

  assign use_negate = op_sel[OP_SUB] | op_sel[OP_SLT] | op_sel[OP_SLTU];

  oh_alu_addsub #(.W(DATA_W)) u_addsub (
    .opa       (src_a),
    .opb       (src_b),
    .negate_b  (use_negate),
    .sum       (adder_sum),
    .carry_out (adder_carry)
  );

  assign lt_signed   = signed_less(src_a[DATA_W-1], src_b[DATA_W-1],
                                   adder_sum[DATA_W-1]);
  assign lt_unsigned = unsigned_less(adder_carry);

  oh_alu_bitwise #(.W(DATA_W)) u_bitwise (
    .opa     (src_a),
    .opb     (src_b),
    .and_out (and_v),
    .nor_out (nor_v),
    .or_out  (or_v),
    .xor_out (xor_v)
  );

  oh_alu_shift #(.W(DATA_W), .SHW(SHW)) u_shift (
    .din   (src_a),
    .amt   (src_b[SHW-1:0]),
    .left  (op_sel[OP_SLL]),
    .arith (op_sel[OP_SRA]),
    .dout  (shift_v)
  );

  assign lane[OP_ADD]  = adder_sum;
  assign lane[OP_SUB]  = adder_sum;
  assign lane[OP_SLT]  = {{(DATA_W-1){1'b0}}, lt_signed};
  assign lane[OP_SLTU] = {{(DATA_W-1){1'b0}}, lt_unsigned};
  assign lane[OP_AND]  = and_v;
  assign lane[OP_NOR]  = nor_v;
  assign lane[OP_OR]   = or_v;
  assign lane[OP_XOR]  = xor_v;
  assign lane[OP_SLL]  = shift_v;
  assign lane[OP_SRL]  = shift_v;
  assign lane[OP_SRA]  = shift_v;
  assign lane[OP_LUI]  = src_b;

  always_comb begin
    result = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      result = result | ({DATA_W{op_sel[i]}} & lane[i]);
    end
  end

  assign sel_valid = $onehot(op_sel);

  always_comb begin
    if (op_sel == '0) begin
      AST_IDLE_ZERO: assert (result == '0) else $error("idle select nonzero"); // R10
    end
    if (sel_valid && op_sel[OP_SUB] && (src_a == src_b)) begin
      AST_SUB_SELF_ZERO: assert (result == '0) else $error("x-x nonzero"); // R2
    end
    if (sel_valid && op_sel[OP_SLT]) begin
      AST_SLT_ONE_BIT: assert (result[DATA_W-1:1] == '0) else $error("slt wide"); // R3
    end
    if (sel_valid && op_sel[OP_SLTU]) begin
      AST_SLTU_ONE_BIT: assert (result[DATA_W-1:1] == '0) else $error("sltu wide"); // R4
    end
    if (sel_valid && op_sel[OP_SLL] && (src_b[SHW-1:0] == '0)) begin
      AST_SHIFT_ZERO_KEEP: assert (result == src_a) else $error("sll by 0"); // R6
    end
    if (sel_valid && op_sel[OP_LUI]) begin
      AST_UPPER_PASS: assert (result == src_b) else $error("upper pass"); // R9
    end
  end

endmodule

// File: tb/sim_oh_alu.sv
module sim_oh_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] op_sel = '0;
  logic [31:0] src_a  = '0;
  logic [31:0] src_b  = '0;
  logic [31:0] result;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] rng = 32'h2545F491;

  always #10 clk = ~clk;

  oh_alu u0 (
    .op_sel (op_sel),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result)
  );

  // Reference model, written from the requirements.
  function automatic logic [31:0] model(input int idx, input logic [31:0] a,
                                        input logic [31:0] b);
    case (idx)
      0:  return a + b;
      1:  return a - b;
      2:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3:  return (a < b) ? 32'd1 : 32'd0;
      4:  return a & b;
      5:  return ~(a | b);
      6:  return a | b;
      7:  return a ^ b;
      8:  return a << b[4:0];
      9:  return a >> b[4:0];
      10: return $unsigned($signed(a) >>> b[4:0]);
      11: return b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6, 7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply_raw(input string tag, input logic [11:0] sel,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] expect_v);
    @(posedge clk);
    op_sel = sel;
    src_a  = a;
    src_b  = b;
    @(negedge clk);
    checks++;
    if (result !== expect_v) begin
      failures++;
      $display("FAIL %s sel=%h a=%h b=%h actual=%h expected=%h",
               tag, sel, a, b, result, expect_v);
    end
  endtask

  task automatic check_op(input int idx, input logic [31:0] a, input logic [31:0] b);
    apply_raw(tag_of(idx), 12'(1) << idx, a, b, model(idx, a, b));
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic t_idle();  // R10
    apply_raw("R10", 12'h000, 32'h0, 32'h0, 32'h0);
    apply_raw("R10", 12'h000, 32'hDEADBEEF, 32'hFFFFFFFF, 32'h0);
  endtask

  task automatic t_add();  // R1
    apply_raw("R1", 12'h001, 32'h1C000000, 32'h4, 32'h1C000004);
    apply_raw("R1", 12'h001, 32'hFFFFFFFF, 32'h1, 32'h0);
    check_op(0, 32'h7FFFFFFF, 32'h7FFFFFFF);
  endtask

  task automatic t_sub();  // R2
    apply_raw("R2", 12'h002, 32'h12345678, 32'h12345678, 32'h0);
    apply_raw("R2", 12'h002, 32'h0, 32'h1, 32'hFFFFFFFF);
    check_op(1, 32'h80000000, 32'h1);
  endtask

  task automatic t_compare();  // R3 R4
    apply_raw("R3", 12'h004, 32'h80000000, 32'h7FFFFFFF, 32'h1);
    apply_raw("R3", 12'h004, 32'h7FFFFFFF, 32'h80000000, 32'h0);
    apply_raw("R3", 12'h004, 32'hFFFFFFFF, 32'h0, 32'h1);
    apply_raw("R3", 12'h004, 32'h5, 32'h5, 32'h0);
    apply_raw("R4", 12'h008, 32'h80000000, 32'h7FFFFFFF, 32'h0);
    apply_raw("R4", 12'h008, 32'h0, 32'hFFFFFFFF, 32'h1);
    apply_raw("R4", 12'h008, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
  endtask

  task automatic t_logic();  // R5
    apply_raw("R5", 12'h010, 32'hF0F0_1234, 32'hFF00_FF00, 32'hF000_1200);
    apply_raw("R5", 12'h020, 32'hF0F0_1234, 32'hFF00_FF00, 32'h000F_00CB);
    apply_raw("R5", 12'h040, 32'hF0F0_1234, 32'hFF00_FF00, 32'hFFF0_FF34);
    apply_raw("R5", 12'h080, 32'hF0F0_1234, 32'hFF00_FF00, 32'h0FF0_ED34);
  endtask

  task automatic t_shift();  // R6 R7 R8
    apply_raw("R6", 12'h100, 32'h8000_0001, 32'h0, 32'h8000_0001);
    apply_raw("R6", 12'h100, 32'h0000_0001, 32'h1F, 32'h8000_0000);
    apply_raw("R6", 12'h100, 32'h0000_00FF, 32'hFFFF_FFE3, 32'h0000_07F8);
    apply_raw("R7", 12'h200, 32'h8000_0000, 32'h1F, 32'h0000_0001);
    apply_raw("R7", 12'h200, 32'hF000_0000, 32'hABCD_EF04, 32'h0F00_0000);
    apply_raw("R8", 12'h400, 32'h8000_0000, 32'h1F, 32'hFFFF_FFFF);
    apply_raw("R8", 12'h400, 32'hF000_0000, 32'hFFFF_FFE4, 32'hFF00_0000);
    apply_raw("R8", 12'h400, 32'h7000_0000, 32'h4, 32'h0700_0000);
    apply_raw("R8", 12'h400, 32'h8765_4321, 32'h0, 32'h8765_4321);
  endtask

  task automatic t_upper();  // R9
    apply_raw("R9", 12'h800, 32'hFFFF_FFFF, 32'h1234_5000, 32'h1234_5000);
    apply_raw("R9", 12'h800, 32'h0, 32'hFFFF_F000, 32'hFFFF_F000);
  endtask

  task automatic t_sweep();  // all operations, pseudo-random operands
    for (int n = 0; n < 150; n++) begin
      for (int idx = 0; idx < 12; idx++) begin
        logic [31:0] a;
        logic [31:0] b;
        rng = next_rand(rng);
        a = rng;
        rng = next_rand(rng);
        b = rng;
        if (n % 5 == 0) b = a;
        check_op(idx, a, b);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // reset state: select idle, result zero (R10)
    if (result !== 32'h0) begin
      failures++;
      $display("FAIL R10 reset actual=%h expected=%h", result, 32'h0);
    end
    t_idle();
    t_add();
    t_sub();
    t_compare();
    t_logic();
    t_shift();
    t_upper();
    t_sweep();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule